// File: doc/BRIEF.md
# MMU Access Fault Classifier

This block decides, for every memory access of a 32-bit processor, whether the access goes to memory and at which physical address, or whether it faults and with which cause. It takes the access address, the access kind (read, write or instruction fetch), the privilege level, a configuration bit that says whether an MMU is fitted, and the result of a TLB lookup made by surrounding logic. The TLB result is a hit flag, three permission bits and a physical page number. The decision is purely combinational, so the pipeline stage that owns the access can act on it in the same cycle.

When an access faults, three fault registers are captured at the next clock edge, and a one-cycle fault strobe is raised alongside them. The registers are the bad-address register, the page-table-entry address register and the data flag of the TLB-miscellaneous state. The page-table-entry address register holds a table base field that software loads, and a page-number field that the block fills in so that a software refill handler can index the page table directly. TLB storage, replacement and the page-table walk are outside this block.

Top module: `mmu_fault_classifier`

## Requirements
- R1: When `mmu_en` is 0, every access maps to its own address (`phys_addr == acc_addr`), `fault` is 0 and `fault_cause` is 0, whatever the mode, kind and TLB inputs are.
- R2: With the MMU enabled and `acc_super` = 1, an address at or above 0xC000_0000 maps to itself and never faults, whatever the TLB inputs are.
- R3: With the MMU enabled and `acc_super` = 1, an address below 0xC000_0000 is translated through the TLB, as set out in R6 to R8.
- R4: With the MMU enabled and `acc_super` = 0, an address at or above 0x8000_0000 faults with cause 1 (supervisor-only address), whatever the TLB inputs are. The fault loads the bad-address register and leaves the page-number field and the data flag unchanged.
- R5: With the MMU enabled and `acc_super` = 0, an address below 0x8000_0000 is translated through the TLB.
- R6: A translated access with `tlb_hit` = 0 faults with cause 2 (TLB miss), whatever the permission bits are.
- R7: On a translated hit, the right that is needed is `tlb_perm[0]` for a read (kind 0), `tlb_perm[1]` for a write (kind 1) and `tlb_perm[2]` for a fetch (kind 2); kind 3 is treated as a read. If that right is missing, the access faults with cause 3 (read), 4 (write) or 5 (fetch).
- R8: A translated hit that has the needed right gives `phys_addr = {tlb_ppn, acc_addr[11:0]}`. Any faulting access drives `phys_addr` to 0.
- R9: At the edge after a valid translation fault (cause 2 to 5), `fault_data` becomes 1 for a read or a write and 0 for a fetch, and `bad_addr` takes the full faulting address.
- R10: `pte_addr` bits [31:22] are the table base. The base changes only when `pte_base_ld` is 1 at an edge, and then takes `pte_base_val`. At the edge after a valid translation fault, bits [21:2] take `acc_addr[31:12]`. Bits [1:0] always read 0.
- R11: `fault_strobe` is 1 for exactly the cycle after an edge at which `acc_valid` and `fault` were both 1. When `acc_valid` is 0, faulting inputs change no register.
- R12: After reset, `fault_strobe`, `bad_addr`, `pte_addr` and `fault_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| acc_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| mmu_en | input | 1 | Configuration: an MMU is fitted |
| tlb_hit | input | 1 | The TLB lookup found the page |
| tlb_perm | input | 3 | Rights of the hit page: bit 0 read, bit 1 write, bit 2 execute |
| tlb_ppn | input | 20 | Physical page number of the hit page |
| pte_base_ld | input | 1 | Load the page-table base field |
| pte_base_val | input | 10 | New page-table base |
| phys_addr | output | 32 | Physical address, 0 when the access faults |
| fault | output | 1 | A valid access faults |
| fault_cause | output | 3 | Cause code, 0 when there is no fault |
| fault_strobe | output | 1 | Registered one-cycle fault pulse |
| bad_addr | output | 32 | Address of the last captured fault |
| pte_addr | output | 32 | Table base, faulting page number, two zero bits |
| fault_data | output | 1 | Last translation fault was a data access |

## Verification
The combinational path is swept over every combination of MMU presence, privilege, the three access kinds, TLB hit or miss and all eight permission patterns. Each combination is applied at eight addresses, chosen on and beside the 0x8000_0000 and 0xC000_0000 boundaries and at 0 and the top of the space. This separates region routing by privilege from the miss-before-permission order, and shows which permission bit each kind consumes. The fault registers are followed through the same sweep against a model that holds its value on non-faulting accesses. This shows that a supervisor-address fault updates only the bad address, and that an access without a fault, or with `acc_valid` low, leaves every register alone. Separate steps load the table base alone and together with a fault, so that the base field is seen to be kept while the page-number field is replaced.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      CS_NONE       = 3'd0,
      CS_SUPER_ADDR = 3'd1,
      CS_TLB_MISS   = 3'd2,
      CS_PERM_RD    = 3'd3,
      CS_PERM_WR    = 3'd4,
      CS_PERM_EX    = 3'd5
   } cause_e;

   typedef enum logic [1:0] {
      RT_IDENT = 2'd0,
      RT_XLATE = 2'd1,
      RT_SUPER = 2'd2
   } route_e;

endpackage

// File: rtl/mfc_region_decode.sv
module mfc_region_decode
   import mfc_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] USER_TOP   = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] BYPASS_LO  = 32'hC000_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              super_mode,
   input  logic              mmu_en,
   output route_e            route
);

   logic in_bypass;
   logic in_kernel;

   assign in_bypass = (addr >= BYPASS_LO);
   assign in_kernel = (addr >= USER_TOP);

   always_comb begin
      if (!mmu_en)
         route = RT_IDENT;
      else if (super_mode)
         route = in_bypass ? RT_IDENT : RT_XLATE;
      else
         route = in_kernel ? RT_SUPER : RT_XLATE;
   end

endmodule

// File: rtl/mfc_perm_check.sv
module mfc_perm_check
   import mfc_pkg::*;
#(
   parameter int N_KINDS = 3
) (
   input  logic               hit,
   input  logic [N_KINDS-1:0] perm,
   input  logic [1:0]         kind,
   output cause_e             cause
);

   localparam int KSEL_W = (N_KINDS > 1) ? $clog2(N_KINDS) : 1;

   logic [N_KINDS-1:0] kind_sel;
   logic               right_ok;

   // one select line per right; the reserved kind falls back to read
   for (genvar k = 0; k < N_KINDS; k++) begin : g_sel
      if (k == 0) begin : g_rd
         assign kind_sel[k] = (kind == ACC_READ) || (kind == ACC_RSVD);
      end else begin : g_other
         assign kind_sel[k] = (kind == k[1:0]);
      end
   end

   assign right_ok = |(kind_sel & perm);

   always_comb begin
      if (!hit)
         cause = CS_TLB_MISS;
      else if (right_ok)
         cause = CS_NONE;
      else if (kind_sel[1])
         cause = CS_PERM_WR;
      else if (kind_sel[2])
         cause = CS_PERM_EX;
      else
         cause = CS_PERM_RD;
   end

   logic [KSEL_W-1:0] unused_w;
   assign unused_w = '0;

endmodule

// File: rtl/mfc_fault_regs.sv
module mfc_fault_regs #(
   parameter int ADDR_W  = 32,
   parameter int VPN_W   = 20,
   parameter int VPN_LSB = 2,
   parameter int BASE_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_any,
   input  logic              cap_xlate,
   input  logic              cap_fetch,
   input  logic [ADDR_W-1:0] addr,
   input  logic              base_ld,
   input  logic [BASE_W-1:0] base_val,
   output logic              strobe,
   output logic [ADDR_W-1:0] bad_addr,
   output logic [ADDR_W-1:0] pte_addr,
   output logic              data_flag
);

   logic [BASE_W-1:0] base_q;
   logic [VPN_W-1:0]  vpn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe    <= 1'b0;
         bad_addr  <= '0;
         base_q    <= '0;
         vpn_q     <= '0;
         data_flag <= 1'b0;
      end else begin
         strobe <= cap_any;
         if (cap_any)
            bad_addr <= addr;
         if (base_ld)
            base_q <= base_val;
         if (cap_xlate) begin
            vpn_q     <= addr[ADDR_W-1 -: VPN_W];
            data_flag <= !cap_fetch;
         end
      end
   end

   assign pte_addr = {base_q, vpn_q, {VPN_LSB{1'b0}}};

endmodule

// File: rtl/mmu_fault_classifier.sv
module mmu_fault_classifier
   import mfc_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                PAGE_BITS = 12,
   parameter int                VPN_LSB   = 2,
   parameter logic [ADDR_W-1:0] USER_TOP  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] BYPASS_LO = 32'hC000_0000,
   parameter int                N_KINDS   = 3,
   localparam int               PPN_W     = ADDR_W - PAGE_BITS,
   localparam int               BASE_W    = ADDR_W - PPN_W - VPN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_kind,
   input  logic              acc_super,
   input  logic              mmu_en,
   input  logic              tlb_hit,
   input  logic [N_KINDS-1:0] tlb_perm,
   input  logic [PPN_W-1:0]  tlb_ppn,
   input  logic              pte_base_ld,
   input  logic [BASE_W-1:0] pte_base_val,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              fault,
   output logic [2:0]        fault_cause,
   output logic              fault_strobe,
   output logic [ADDR_W-1:0] bad_addr,
   output logic [ADDR_W-1:0] pte_addr,
   output logic              fault_data
);

   // elaboration-time parameter checks
   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("page size does not fit the address width");
   end
   if (VPN_LSB < 1 || BASE_W < 1) begin : g_bad_pte
      $error("page-table-entry address layout does not fit");
   end
   if (N_KINDS != 3) begin : g_bad_kinds
      $error("exactly three access rights are supported");
   end
   if (BYPASS_LO < USER_TOP) begin : g_bad_regions
      $error("bypass region must lie inside the supervisor region");
   end

   route_e route;
   cause_e xl_cause;
   cause_e cause;

   mfc_region_decode #(
      .ADDR_W    (ADDR_W),
      .USER_TOP  (USER_TOP),
      .BYPASS_LO (BYPASS_LO)
   ) u_region (
      .addr       (acc_addr),
      .super_mode (acc_super),
      .mmu_en     (mmu_en),
      .route      (route)
   );

   mfc_perm_check #(
      .N_KINDS (N_KINDS)
   ) u_perm (
      .hit   (tlb_hit),
      .perm  (tlb_perm),
      .kind  (acc_kind),
      .cause (xl_cause)
   );

   always_comb begin
      unique case (route)
         RT_SUPER: cause = CS_SUPER_ADDR;
         RT_XLATE: cause = xl_cause;
         default:  cause = CS_NONE;
      endcase
   end

   always_comb begin
      if (cause != CS_NONE)
         phys_addr = '0;
      else if (route == RT_XLATE)
         phys_addr = {tlb_ppn, acc_addr[PAGE_BITS-1:0]};
      else
         phys_addr = acc_addr;
   end

   assign fault_cause = cause;
   assign fault       = acc_valid && (cause != CS_NONE);

   logic cap_xlate;
   assign cap_xlate = fault && (route == RT_XLATE);

   mfc_fault_regs #(
      .ADDR_W  (ADDR_W),
      .VPN_W   (PPN_W),
      .VPN_LSB (VPN_LSB),
      .BASE_W  (BASE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_any   (fault),
      .cap_xlate (cap_xlate),
      .cap_fetch (acc_kind == ACC_FETCH),
      .addr      (acc_addr),
      .base_ld   (pte_base_ld),
      .base_val  (pte_base_val),
      .strobe    (fault_strobe),
      .bad_addr  (bad_addr),
      .pte_addr  (pte_addr),
      .data_flag (fault_data)
   );

endmodule

// File: rtl/mfc_checker.sv
module mfc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic [31:0] acc_addr,
   input logic        acc_super,
   input logic        mmu_en,
   input logic        pte_base_ld,
   input logic [31:0] phys_addr,
   input logic        fault,
   input logic [2:0]  fault_cause,
   input logic        fault_strobe,
   input logic [31:0] bad_addr,
   input logic [31:0] pte_addr
);

   // R1
   no_mmu_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mmu_en |-> (fault_cause == 3'd0 && phys_addr == acc_addr));

   // R2
   bypass_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mmu_en && acc_super && acc_addr >= 32'hC000_0000) |->
         (fault_cause == 3'd0 && phys_addr == acc_addr));

   // R4
   user_high_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mmu_en && !acc_super && acc_addr >= 32'h8000_0000) |-> fault_cause == 3'd1);

   // R8
   fault_zero_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_cause != 3'd0) |-> phys_addr == 32'd0);

   // R11
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && fault) |=> fault_strobe);

   // R11
   strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_strobe |-> $past(acc_valid && fault_cause != 3'd0));

   // R9
   bad_addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_strobe |-> bad_addr == $past(acc_addr));

   // R10
   base_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pte_base_ld |=> $stable(pte_addr[31:22]));

   // R10
   pte_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pte_addr[1:0] == 2'b00);

endmodule

bind mmu_fault_classifier mfc_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_addr     (acc_addr),
   .acc_super    (acc_super),
   .mmu_en       (mmu_en),
   .pte_base_ld  (pte_base_ld),
   .phys_addr    (phys_addr),
   .fault        (fault),
   .fault_cause  (fault_cause),
   .fault_strobe (fault_strobe),
   .bad_addr     (bad_addr),
   .pte_addr     (pte_addr)
);

// File: tb/sim_mmu_fault_classifier.sv
module sim_mmu_fault_classifier;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_kind = '0;
   logic        acc_super = 1'b0;
   logic        mmu_en = 1'b0;
   logic        tlb_hit = 1'b0;
   logic [2:0]  tlb_perm = '0;
   logic [19:0] tlb_ppn = '0;
   logic        pte_base_ld = 1'b0;
   logic [9:0]  pte_base_val = '0;
   logic [31:0] phys_addr;
   logic        fault;
   logic [2:0]  fault_cause;
   logic        fault_strobe;
   logic [31:0] bad_addr;
   logic [31:0] pte_addr;
   logic        fault_data;

   int total = 0;
   int bad = 0;

   // bench model of the fault registers
   logic [31:0] m_bad;
   logic [9:0]  m_base;
   logic [19:0] m_vpn;
   logic        m_data;

   always #10 clk = ~clk;

   mmu_fault_classifier u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_kind(acc_kind), .acc_super(acc_super), .mmu_en(mmu_en),
      .tlb_hit(tlb_hit), .tlb_perm(tlb_perm), .tlb_ppn(tlb_ppn),
      .pte_base_ld(pte_base_ld), .pte_base_val(pte_base_val),
      .phys_addr(phys_addr), .fault(fault), .fault_cause(fault_cause),
      .fault_strobe(fault_strobe), .bad_addr(bad_addr), .pte_addr(pte_addr),
      .fault_data(fault_data)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_regs(input logic exp_strobe, input string req);
      logic [31:0] ep;
      ep = {m_base, m_vpn, 2'b00};
      check(fault_strobe == exp_strobe, {req, " strobe"}, 64'(fault_strobe), 64'(exp_strobe));
      check(bad_addr == m_bad, {req, " bad_addr"}, 64'(bad_addr), 64'(m_bad));
      check(pte_addr == ep, {req, " pte_addr"}, 64'(pte_addr), 64'(ep));
      check(fault_data == m_data, {req, " data flag"}, 64'(fault_data), 64'(m_data));
   endtask

   function automatic logic [31:0] pick_addr(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h1234_5ABC;
         2: return 32'h7FFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'h9ABC_D123;
         5: return 32'hBFFF_FFFF;
         6: return 32'hC000_0000;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_bad = '0; m_base = '0; m_vpn = '0; m_data = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R12 reset state
      check_regs(1'b0, "R12 reset");

      // R10 base load alone
      @(negedge clk);
      pte_base_ld = 1'b1; pte_base_val = 10'h2B5;
      @(posedge clk) #1;
      m_base = 10'h2B5;
      @(negedge clk) pte_base_ld = 1'b0;
      check_regs(1'b0, "R10 base load");

      for (int ai = 0; ai < 8; ai++)
      for (int k = 0; k < 3; k++)
      for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
      for (int h = 0; h < 2; h++)
      for (int p = 0; p < 8; p++) begin
         logic [31:0] a, ephys;
         logic [2:0]  ecause;
         logic        xl, need;
         string       req;
         a = pick_addr(ai);
         @(negedge clk);
         acc_valid = 1'b1; acc_addr = a; acc_kind = 2'(k);
         acc_super = s[0]; mmu_en = m[0]; tlb_hit = h[0]; tlb_perm = 3'(p);
         tlb_ppn = 20'hA5F00 ^ 20'(ai * 37 + p);
         // expected from the requirements
         xl = 1'b0; ecause = 3'd0; ephys = a;
         if (m == 0) req = "R1";
         else if (s == 1 && a >= 32'hC000_0000) req = "R2";
         else if (s == 0 && a >= 32'h8000_0000) begin req = "R4"; ecause = 3'd1; end
         else begin
            xl = 1'b1;
            req = (s == 1) ? "R3" : "R5";
            need = (k == 0) ? tlb_perm[0] : (k == 1) ? tlb_perm[1] : tlb_perm[2];
            if (h == 0) begin ecause = 3'd2; req = {req, "/R6"}; end
            else if (!need) begin ecause = 3'(3 + k); req = {req, "/R7"}; end
            else begin ephys = {tlb_ppn, a[11:0]}; req = {req, "/R8"}; end
         end
         if (ecause != 3'd0) ephys = 32'd0;
         #2;
         check(fault_cause == ecause && fault == (ecause != 3'd0) && phys_addr == ephys,
               req, {29'd0, fault_cause, phys_addr}, {29'd0, ecause, ephys});
         if (ecause != 3'd0) begin
            m_bad = a;
            if (xl) begin m_vpn = a[31:12]; m_data = (k != 2); end
         end
         @(posedge clk) #1;
         check_regs(ecause != 3'd0, ecause == 3'd1 ? "R4/R11" : (xl ? "R9/R10/R11" : "R11"));
      end

      // R11 faulting inputs with acc_valid low change nothing
      @(negedge clk);
      acc_valid = 1'b0; acc_addr = 32'h0345_6000; acc_kind = 2'd0;
      acc_super = 1'b0; mmu_en = 1'b1; tlb_hit = 1'b0;
      #2;
      check(fault == 1'b0, "R11 valid low", 64'(fault), 64'd0);
      @(posedge clk) #1;
      check_regs(1'b0, "R11 valid low");

      // R10 base load together with a fetch miss; R7 reserved kind as read
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = 32'h2468_ACE0; acc_kind = 2'd2;
      pte_base_ld = 1'b1; pte_base_val = 10'h14A;
      @(posedge clk) #1;
      m_base = 10'h14A; m_vpn = 20'h2468A; m_bad = 32'h2468_ACE0; m_data = 1'b0;
      check_regs(1'b1, "R10/R9 load with fault");
      @(negedge clk);
      pte_base_ld = 1'b0; acc_kind = 2'd3; tlb_hit = 1'b1; tlb_perm = 3'b110;
      #2;
      check(fault_cause == 3'd3, "R7 kind 3 as read", 64'(fault_cause), 64'd3);
      @(negedge clk) acc_valid = 1'b0;
      @(posedge clk) #1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule